// File: doc/BRIEF.md
# Instruction Cycle Timing Generator

This block is the per-cycle sequencer of a small 8-bit processor core. Every clock it presents a set of six active-low time-code bits. Instruction decode combines these bits with the opcode to choose the datapath controls for the current cycle. The bits are named, from bit 0 upward: final cycle (F), fetch-plus (P), and the step bits S2, S3, S4 and S5.

The sequencer has ten effective states. Six of them assert exactly one bit. Two of them assert a pair: F with P, and F with S2. The last two states assert no bit at all. A separate blanking flag tells those two apart. The flag is high in the "quiet fetch" state and low in the "late idle" state that follows S5.

Decode steers the sequence with five request inputs:
- a two-cycle indication, sampled during opcode fetch;
- an end-of-instruction request;
- three branch-end requests: not taken, taken within the page, and taken across a page.

All requests are sampled on the rising clock edge. The outputs come straight from the state register, so the time code never glitches.

Top module: `cycle_timer`

## Requirements
- R1: Reset (rst_n low) is synchronous and overrides every request at the rising edge.
  - If the current code has F active (tcode_n_o[0]==0), the next code is F+P (tcode_n_o=6'b111100, clear_o=0).
  - Otherwise the sequence is aborted and the next code is F alone (6'b111110, clear_o=0).
  - Holding reset therefore settles in F+P.
- R2: After any cycle with F active and reset high at the edge, the next code is P alone (6'b111101, clear_o=0). This covers F, F+S2 and F+P.
- R3: In an opcode fetch cycle (P alone, or quiet fetch), the next code depends on two_cycle_i.
  - With two_cycle_i high, the next code is F+S2 (6'b111010).
  - Otherwise the next code is S2 alone (6'b111011).
  - All other requests are ignored in a fetch cycle.
- R4: With no request, the step bits advance S2→S3→S4→S5→late idle→F. The codes are 6'b111011, 6'b110111, 6'b101111, 6'b011111, then 6'b111111 with clear_o=0, then 6'b111110. From late idle the next code is always F, whatever the requests.
- R5: end_req_i high in a step state (S2..S5) makes the next code F alone.
- R6: In a step state, br_not_taken_i or br_same_page_i makes the next code quiet fetch (6'b111111, clear_o=1).
  - A branch not taken thus ends on an S2 cycle.
  - A taken branch within the page ends on an S3 cycle.
- R7: br_cross_page_i high in a step state makes the next code F alone.
- R8: Requests are resolved in this priority order: reset, then end_req_i, then br_cross_page_i, then the two other branch requests, then normal advance.
- R9: clear_o is high only in quiet fetch. In every cycle with clear_o high, all six time-code bits are inactive (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset / abort |
| two_cycle_i | input | 1 | Current instruction is strictly two cycles (sampled in fetch) |
| end_req_i | input | 1 | Next cycle is the instruction's final cycle |
| br_not_taken_i | input | 1 | Branch not taken; this cycle ends the branch |
| br_same_page_i | input | 1 | Branch taken inside the page; this cycle ends the branch |
| br_cross_page_i | input | 1 | Branch taken across a page; final cycle follows |
| tcode_n_o | output | 6 | Active-low time code: bit0 F, bit1 P, bits2..5 S2..S5 |
| clear_o | output | 1 | Blanking flag, high only in quiet fetch |

## Verification
Every request acts on the rising edge where it is sampled, and its effect on tcode_n_o and clear_o appears exactly one clock later, because the outputs are the state register itself. The bench changes inputs on the falling edge and steps a behavioural model of the ten states at the same rising edge. It compares a quarter period after that edge, so each result is checked in the single cycle in which it is due. Directed scenarios walk each documented sequence, the priority cases and the abort path. A long stretch of random requests is then compared against the model on every clock.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;
  localparam int CODE_W = 6;
  localparam int STATE_W = CODE_W + 1;

  // {clear, S5, S4, S3, S2, P, F}; code bits active low
  typedef enum logic [STATE_W-1:0] {
    ST_PLUS  = 7'b0_111101,
    ST_QUIET = 7'b1_111111,
    ST_S2    = 7'b0_111011,
    ST_F_S2  = 7'b0_111010,
    ST_S3    = 7'b0_110111,
    ST_S4    = 7'b0_101111,
    ST_S5    = 7'b0_011111,
    ST_IDLE  = 7'b0_111111,
    ST_F     = 7'b0_111110,
    ST_F_P   = 7'b0_111100
  } tstate_t;
endpackage

// File: rtl/cycle_timer_next.sv
module cycle_timer_next
  import cycle_timer_pkg::*;
(
  input  tstate_t cur_i,
  input  logic    rst_n,
  input  logic    two_cycle_i,
  input  logic    end_req_i,
  input  logic    br_not_taken_i,
  input  logic    br_same_page_i,
  input  logic    br_cross_page_i,
  output tstate_t nxt_o
);
  logic final_active;
  logic step_state;

  // F is bit 0 of the code, active low
  assign final_active = ~cur_i[0];
  assign step_state = (cur_i == ST_S2) || (cur_i == ST_S3) ||
                      (cur_i == ST_S4) || (cur_i == ST_S5);

  always_comb begin
    nxt_o = ST_F;
    if (!rst_n) begin
      nxt_o = final_active ? ST_F_P : ST_F;
    end else if (step_state) begin
      if (end_req_i || br_cross_page_i) begin
        nxt_o = ST_F;
      end else if (br_not_taken_i || br_same_page_i) begin
        nxt_o = ST_QUIET;
      end else begin
        case (cur_i)
          ST_S2:   nxt_o = ST_S3;
          ST_S3:   nxt_o = ST_S4;
          ST_S4:   nxt_o = ST_S5;
          default: nxt_o = ST_IDLE;
        endcase
      end
    end else begin
      case (cur_i)
        ST_PLUS, ST_QUIET:     nxt_o = two_cycle_i ? ST_F_S2 : ST_S2;
        ST_F, ST_F_S2, ST_F_P: nxt_o = ST_PLUS;
        ST_IDLE:               nxt_o = ST_F;
        default:               nxt_o = ST_F;
      endcase
    end
  end
endmodule

// File: rtl/cycle_timer_reg.sv
module cycle_timer_reg
  import cycle_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tstate_t nxt_i,
  output tstate_t cur_o
);
  always_ff @(posedge clk) begin
    cur_o <= nxt_i;
  end

  // R1: reset while F is active yields F+P
  a_r1_reset_on_final: assert property (@(posedge clk)
    (!rst_n && !cur_o[0]) |=> (cur_o == ST_F_P));

  // R1: reset while F is inactive aborts to F alone
  a_r1_abort_to_final: assert property (@(posedge clk)
    (!rst_n && (cur_o[0] === 1'b1)) |=> (cur_o == ST_F));

  // R2: a cycle with F active is followed by P alone
  a_r2_fetch_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_o[0]) |=> (cur_o == ST_PLUS));

  // R4: late idle always leads to F
  a_r4_idle_to_final: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_o == ST_IDLE) |=> (cur_o == ST_F));

  // R9: blanking flag only with every code bit inactive
  a_r9_clear_blank: assert property (@(posedge clk) disable iff (!rst_n)
    cur_o[STATE_W-1] |-> (cur_o[CODE_W-1:0] == '1));
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cycle_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_cycle_i,
  input  logic              end_req_i,
  input  logic              br_not_taken_i,
  input  logic              br_same_page_i,
  input  logic              br_cross_page_i,
  output logic [CODE_W-1:0] tcode_n_o,
  output logic              clear_o
);
  tstate_t cur_q;
  tstate_t nxt_d;

  cycle_timer_next u_next (
    .cur_i           (cur_q),
    .rst_n           (rst_n),
    .two_cycle_i     (two_cycle_i),
    .end_req_i       (end_req_i),
    .br_not_taken_i  (br_not_taken_i),
    .br_same_page_i  (br_same_page_i),
    .br_cross_page_i (br_cross_page_i),
    .nxt_o           (nxt_d)
  );

  cycle_timer_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt_i (nxt_d),
    .cur_o (cur_q)
  );

  assign tcode_n_o = cur_q[CODE_W-1:0];
  assign clear_o   = cur_q[STATE_W-1];

  // R5/R8: end request in a step state wins over branch requests
  a_r8_end_first: assert property (@(posedge clk) disable iff (!rst_n)
    (end_req_i && (cur_q == ST_S2 || cur_q == ST_S3 ||
                   cur_q == ST_S4 || cur_q == ST_S5))
    |=> (tcode_n_o == 6'b111110 && !clear_o));

  // R3: two-cycle indication in fetch gives F+S2
  a_r3_short_instr: assert property (@(posedge clk) disable iff (!rst_n)
    (two_cycle_i && (cur_q == ST_PLUS || cur_q == ST_QUIET))
    |=> (tcode_n_o == 6'b111010));
endmodule

// File: tb/cycle_timer_tb.sv
module cycle_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_cycle_i = 1'b0, end_req_i = 1'b0;
  logic br_not_taken_i = 1'b0, br_same_page_i = 1'b0, br_cross_page_i = 1'b0;
  logic [5:0] tcode_n_o;
  logic clear_o;

  int checks = 0;
  int failures = 0;
  int mstate = 9;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cycle_timer u_dut (
    .clk(clk), .rst_n(rst_n), .two_cycle_i(two_cycle_i), .end_req_i(end_req_i),
    .br_not_taken_i(br_not_taken_i), .br_same_page_i(br_same_page_i),
    .br_cross_page_i(br_cross_page_i), .tcode_n_o(tcode_n_o), .clear_o(clear_o)
  );

  // model states: 0 P, 1 quiet fetch, 2 S2, 3 F+S2, 4 S3, 5 S4, 6 S5, 7 late idle, 8 F, 9 F+P
  function automatic logic [6:0] code_of(int s);
    case (s)
      0: return 7'b0_111101;
      1: return 7'b1_111111;
      2: return 7'b0_111011;
      3: return 7'b0_111010;
      4: return 7'b0_110111;
      5: return 7'b0_101111;
      6: return 7'b0_011111;
      7: return 7'b0_111111;
      8: return 7'b0_111110;
      default: return 7'b0_111100;
    endcase
  endfunction

  function automatic int step_model(int s, bit r, bit two, bit fin, bit nt, bit sp, bit cp);
    if (!r) return (s == 3 || s == 8 || s == 9) ? 9 : 8;
    if (s == 0 || s == 1) return two ? 3 : 2;
    if (s == 3 || s == 8 || s == 9) return 0;
    if (s == 7) return 8;
    if (fin || cp) return 8;
    if (nt || sp) return 1;
    case (s)
      2: return 4;
      4: return 5;
      5: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic check(string tag, logic [6:0] exp);
    checks++;
    if ({clear_o, tcode_n_o} !== exp) begin
      failures++;
      $display("FAIL %s: got clear=%b code=%b expected clear=%b code=%b",
               tag, clear_o, tcode_n_o, exp[6], exp[5:0]);
    end
  endtask

  // drive on falling edge, advance model at rising edge, compare a quarter period later
  task automatic cyc(bit r, bit two, bit fin, bit nt, bit sp, bit cp, string tag = "");
    string t;
    @(negedge clk);
    rst_n = r; two_cycle_i = two; end_req_i = fin;
    br_not_taken_i = nt; br_same_page_i = sp; br_cross_page_i = cp;
    @(posedge clk);
    t = (tag == "") ? "model" : tag;
    mstate = step_model(mstate, r, two, fin, nt, sp, cp);
    #5;
    check(t, code_of(mstate));
  endtask

  initial begin
    repeat (3) cyc(0, 0, 0, 0, 0, 0, "R1 reset held F+P");
    check("R1 reset state", 7'b0_111100);
    cyc(1, 0, 0, 0, 0, 0, "R2 P after F+P");
    check("R2 fetch plus", 7'b0_111101);
    // long instruction walks every step
    cyc(1, 0, 0, 0, 0, 0, "R3 S2");
    cyc(1, 0, 0, 0, 0, 0, "R4 S3");
    cyc(1, 0, 0, 0, 0, 0, "R4 S4");
    cyc(1, 0, 0, 0, 0, 0, "R4 S5");
    cyc(1, 0, 0, 0, 0, 0, "R4 idle");
    check("R9 late idle clear low", 7'b0_111111);
    cyc(1, 1, 1, 1, 1, 1, "R4 idle to F ignores requests");
    cyc(1, 0, 0, 0, 0, 0, "R2 fetch");
    // short instruction
    cyc(1, 1, 0, 0, 0, 0, "R3 F+S2");
    check("R3 two cycle code", 7'b0_111010);
    cyc(1, 0, 0, 0, 0, 0, "R2 after F+S2");
    // three-cycle instruction
    cyc(1, 0, 0, 0, 0, 0, "R3 S2");
    cyc(1, 0, 1, 0, 0, 0, "R5 end at S2");
    cyc(1, 0, 0, 0, 0, 0, "R2 fetch");
    // branch not taken
    cyc(1, 0, 0, 0, 0, 0, "R3 S2");
    cyc(1, 0, 0, 1, 0, 0, "R6 not taken");
    check("R9 quiet fetch clear high", 7'b1_111111);
    cyc(1, 1, 0, 0, 0, 0, "R3 F+S2 from quiet fetch");
    cyc(1, 0, 0, 0, 0, 0, "R2 fetch");
    // branch taken same page
    cyc(1, 0, 0, 0, 0, 0, "R3 S2");
    cyc(1, 0, 0, 0, 0, 0, "R4 S3");
    cyc(1, 0, 0, 0, 1, 0, "R6 same page");
    cyc(1, 0, 0, 0, 0, 0, "R3 S2 from quiet");
    cyc(1, 0, 0, 0, 0, 0, "R4 S3");
    cyc(1, 0, 0, 0, 0, 1, "R7 cross page");
    check("R7 final", 7'b0_111110);
    cyc(1, 0, 1, 1, 1, 1, "R2 requests ignored in F");
    cyc(1, 0, 1, 1, 1, 1, "R3 requests ignored in fetch");
    cyc(1, 0, 1, 1, 0, 0, "R8 end beats not taken");
    cyc(1, 0, 0, 0, 0, 0, "R2 fetch");
    cyc(1, 0, 0, 0, 0, 0, "R3 S2");
    cyc(1, 0, 0, 1, 1, 1, "R8 cross beats others");
    check("R8 cross priority", 7'b0_111110);
    cyc(1, 0, 0, 0, 0, 0, "R2 fetch");
    cyc(1, 0, 0, 0, 0, 0, "R3 S2");
    cyc(1, 0, 0, 0, 0, 0, "R4 S3");
    cyc(0, 0, 0, 0, 0, 0, "R1 abort to F");
    check("R1 abort", 7'b0_111110);
    cyc(0, 0, 1, 0, 0, 0, "R1 reset on F gives F+P");
    cyc(1, 0, 0, 0, 0, 0, "R2 fetch after reset");
    // random requests against the model
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 40) != 0, $urandom % 2, ($urandom % 6) == 0,
          ($urandom % 7) == 0, ($urandom % 7) == 0, ($urandom % 9) == 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule